// File: doc/BRIEF.md
# First-Order Pole-Zero IIR Section

A streaming fixed-point filter section with one pole at 1/4 and one zero at 2. Its transfer function is (1 - 2 z^-1)/(1 - 1/4 z^-1). It uses the shared-delay (Direct Form II) arrangement. A single state register holds the previous value of the internal signal `v`. The pole recursion and the zero tap both read that register. Each accepted input sample advances the recursion once and produces exactly one output sample, one clock later.

Samples are 16-bit signed two's complement. The state keeps 2 extra integer guard bits and 4 fraction bits, so it is 22 bits wide. The pole and zero coefficients are powers of two, so the datapath uses only shifts and adders and has no multiplier. The output is the internal result rounded toward minus infinity to an integer, then clamped to the 16-bit signed range.

Top module: `iir1_pz_section`

## Requirements
- R1: While `rst_ni` is low, `y_valid_o` is 0, `y_o` is 0 and the state is 0. The first sample after reset therefore gives `y_o` equal to that sample.
- R2: `y_valid_o` equals `x_valid_i` delayed by exactly one clock cycle.
- R3: On every cycle with `x_valid_i` high, the state in units of 1/16 becomes `s_new = 16*x_i + floor(s_old/4)`.
- R4: The output sample for that input is `y_o = floor((s_new - 2*s_old)/16)`, saturated. A unit-scaled impulse of 1000 followed by zeros gives 1000, -1750, -438, -110, -28.
- R5: On cycles with `x_valid_i` low, the state does not change. Gaps between samples have no effect on the output sequence.
- R6: An output above 32767 is clamped to 32767 and an output below -32768 is clamped to -32768. It never wraps.
- R7: `y_o` holds its last value whenever no new output is produced (`y_valid_o` low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| x_i | input | 16 | Signed input sample |
| x_valid_i | input | 1 | Input sample strobe |
| y_o | output | 16 | Signed output sample |
| y_valid_o | output | 1 | Output sample strobe |

## Verification
The pole update and the zero tap fall in the same cycle. On every accepted sample the state register is overwritten, while the feed-forward difference must still use its old value. Back-to-back valid samples exercise this, in the impulse table, in an alternating full-scale pattern and in saturating runs. Each output is compared against a bench model that computes the new state from the pre-update state and forms the output from both values. Gaps between samples and a reset in mid-stream show that the state neither advances nor leaks across idle cycles.

// File: rtl/iir1_pkg.sv
package iir1_pkg;
  parameter int unsigned DATA_W     = 16;
  parameter int unsigned GUARD_W    = 2;
  parameter int unsigned FRAC_W     = 4;
  parameter int unsigned POLE_SHIFT = 2;  // pole = 2^-POLE_SHIFT
  parameter int unsigned ZERO_SHIFT = 1;  // zero = 2^ZERO_SHIFT
endpackage

// File: rtl/iir1_pole.sv
// State recursion: v_next = x + v * 2^-POLE_SHIFT (positive feedback)
module iir1_pole #(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned GUARD_W    = 2,
  parameter int unsigned FRAC_W     = 4,
  parameter int unsigned POLE_SHIFT = 2,
  localparam int unsigned STATE_W   = DATA_W + GUARD_W + FRAC_W
) (
  input  logic signed [DATA_W-1:0]  x_i,
  input  logic signed [STATE_W-1:0] v_q_i,
  output logic signed [STATE_W-1:0] v_next_o
);
  logic signed [STATE_W-1:0] x_ext;
  logic signed [STATE_W-1:0] fb;

  assign x_ext    = {{GUARD_W{x_i[DATA_W-1]}}, x_i, {FRAC_W{1'b0}}};
  assign fb       = v_q_i >>> POLE_SHIFT;
  assign v_next_o = x_ext + fb;
endmodule

// File: rtl/iir1_zero.sv
// Feed-forward tap: acc = v_next - v_q * 2^ZERO_SHIFT
module iir1_zero #(
  parameter int unsigned STATE_W    = 22,
  parameter int unsigned ZERO_SHIFT = 1,
  localparam int unsigned ACC_W     = STATE_W + ZERO_SHIFT + 1
) (
  input  logic signed [STATE_W-1:0] v_next_i,
  input  logic signed [STATE_W-1:0] v_q_i,
  output logic signed [ACC_W-1:0]   acc_o
);
  logic signed [ACC_W-1:0] cur_ext;
  logic signed [ACC_W-1:0] old_ext;

  assign cur_ext = {{(ACC_W-STATE_W){v_next_i[STATE_W-1]}}, v_next_i};
  assign old_ext = {{(ACC_W-STATE_W){v_q_i[STATE_W-1]}}, v_q_i};
  assign acc_o   = cur_ext - (old_ext <<< ZERO_SHIFT);
endmodule

// File: rtl/iir1_sat.sv
// Drop fraction bits (floor) and clamp to the signed output range
module iir1_sat #(
  parameter int unsigned ACC_W  = 24,
  parameter int unsigned FRAC_W = 4,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned INT_W = ACC_W - FRAC_W
) (
  input  logic signed [ACC_W-1:0]  acc_i,
  output logic signed [DATA_W-1:0] q_o
);
  localparam logic signed [INT_W-1:0] MAX_V =
    {{(INT_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic signed [INT_W-1:0] MIN_V =
    {{(INT_W-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};

  logic signed [INT_W-1:0] whole;
  assign whole = acc_i[ACC_W-1:FRAC_W];

  always_comb begin
    if (whole > MAX_V)      q_o = {1'b0, {(DATA_W-1){1'b1}}};
    else if (whole < MIN_V) q_o = {1'b1, {(DATA_W-1){1'b0}}};
    else                    q_o = whole[DATA_W-1:0];
  end
endmodule

// File: rtl/iir1_pz_section.sv
module iir1_pz_section
  import iir1_pkg::*;
#(
  parameter int unsigned DW  = DATA_W,
  parameter int unsigned GW  = GUARD_W,
  parameter int unsigned FW  = FRAC_W,
  parameter int unsigned PSH = POLE_SHIFT,
  parameter int unsigned ZSH = ZERO_SHIFT,
  localparam int unsigned SW = DW + GW + FW,
  localparam int unsigned AW = SW + ZSH + 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic signed [DW-1:0] x_i,
  input  logic                 x_valid_i,
  output logic signed [DW-1:0] y_o,
  output logic                 y_valid_o
);
  logic signed [SW-1:0] v_q;     // single shared delay element
  logic signed [SW-1:0] v_next;
  logic signed [AW-1:0] acc;
  logic signed [DW-1:0] y_sat;
  logic signed [DW-1:0] y_q;
  logic                 yv_q;

  iir1_pole #(.DATA_W(DW), .GUARD_W(GW), .FRAC_W(FW), .POLE_SHIFT(PSH)) u_pole (
    .x_i      (x_i),
    .v_q_i    (v_q),
    .v_next_o (v_next)
  );

  iir1_zero #(.STATE_W(SW), .ZERO_SHIFT(ZSH)) u_zero (
    .v_next_i (v_next),
    .v_q_i    (v_q),
    .acc_o    (acc)
  );

  iir1_sat #(.ACC_W(AW), .FRAC_W(FW), .DATA_W(DW)) u_sat (
    .acc_i (acc),
    .q_o   (y_sat)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q  <= '0;
      y_q  <= '0;
      yv_q <= 1'b0;
    end else begin
      yv_q <= x_valid_i;
      if (x_valid_i) begin
        v_q <= v_next;
        y_q <= y_sat;
      end
    end
  end

  assign y_o       = y_q;
  assign y_valid_o = yv_q;
endmodule

// File: rtl/iir1_pz_chk.sv
module iir1_pz_chk #(
  parameter int unsigned DW = 16,
  parameter int unsigned SW = 22
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 x_valid_i,
  input logic                 y_valid_o,
  input logic signed [DW-1:0] y_o,
  input logic signed [SW-1:0] state_i
);
  // R2
  valid_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    x_valid_i |=> y_valid_o);
  // R2
  valid_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !x_valid_i |=> !y_valid_o);
  // R5
  state_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !x_valid_i |=> $stable(state_i));
  // R7
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !x_valid_i |=> $stable(y_o));
  // R1
  reset_clear_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (!y_valid_o && y_o == '0 && state_i == '0));
endmodule

bind iir1_pz_section iir1_pz_chk #(.DW(DW), .SW(SW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .x_valid_i (x_valid_i),
  .y_valid_o (y_valid_o),
  .y_o       (y_o),
  .state_i   (v_q)
);

// File: tb/iir1_pz_section_tb.sv
module iir1_pz_section_tb;
  logic               clk = 1'b0;
  logic               rst_ni = 1'b0;
  logic signed [15:0] x_i = '0;
  logic               x_valid_i = 1'b0;
  logic signed [15:0] y_o;
  logic               y_valid_o;

  int checks = 0;
  int failures = 0;
  int mstate = 0;   // model state, units of 1/16
  bit done = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  iir1_pz_section u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .x_i(x_i), .x_valid_i(x_valid_i),
    .y_o(y_o), .y_valid_o(y_valid_o)
  );

  // impulse table: stimulus and expected output
  localparam int N_IMP = 5;
  localparam int IMP_X [N_IMP] = '{1000, 0, 0, 0, 0};
  localparam int IMP_Y [N_IMP] = '{1000, -1750, -438, -110, -28};

  function automatic int model_step(int x);
    int s_new, acc, q;
    s_new  = x * 16 + (mstate >>> 2);
    acc    = s_new - 2 * mstate;
    q      = acc >>> 4;
    mstate = s_new;
    if (q > 32767)  q = 32767;
    if (q < -32768) q = -32768;
    return q;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one clock: drive at negedge, sample just after posedge
  task automatic step(bit vld, int x);
    @(negedge clk);
    x_valid_i = vld;
    x_i = 16'(x);
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    x_valid_i = 1'b0;
    mstate = 0;
    #1;
    check("R1 y_valid in reset", int'(y_valid_o), 0);
    check("R1 y in reset", int'(y_o), 0);
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic send_chk(string req, int x);
    int exp;
    exp = model_step(x);
    step(1'b1, x);
    check(req, int'(y_valid_o), 1);
    check(req, int'(y_o), exp);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    do_reset();

    // R3 R4: impulse table walked back to back
    for (int i = 0; i < N_IMP; i++) begin
      void'(model_step(IMP_X[i]));
      step(1'b1, IMP_X[i]);
      check("R4 impulse valid", int'(y_valid_o), 1);
      check("R4 impulse value", int'(y_o), IMP_Y[i]);
    end

    // R5 R7 R2: gaps do not advance state or change output
    do_reset();
    send_chk("R3 gap first", 800);
    for (int g = 0; g < 3; g++) begin
      step(1'b0, 12345);
      check("R2 idle no valid", int'(y_valid_o), 0);
      check("R7 output held", int'(y_o), 800);
    end
    send_chk("R5 after gap", 0);
    send_chk("R5 after gap 2", -300);

    // R3: alternating pattern, back to back
    for (int i = 0; i < 8; i++)
      send_chk("R3 alternating", (i % 2 == 0) ? 20000 : -20000);

    // R6: positive full scale run
    do_reset();
    send_chk("R6 pos first", 32767);
    send_chk("R6 pos second", 32767);
    send_chk("R6 clamp low", 32767);
    check("R6 min value", int'(y_o), -32768);
    send_chk("R6 clamp low again", 32767);

    // R6: negative full scale run
    do_reset();
    send_chk("R6 neg first", -32768);
    send_chk("R6 neg second", -32768);
    send_chk("R6 clamp high", -32768);
    check("R6 max value", int'(y_o), 32767);

    // R1: reset mid-stream, first sample passes through
    send_chk("R3 pre reset", 5000);
    do_reset();
    send_chk("R1 first after reset", -1234);
    check("R1 passthrough", int'(y_o), -1234);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule